// File: doc/BRIEF.md
# Floating-point status and trap controller

This block holds the status and control word of a floating-point unit that runs single- and double-precision operations. Software writes the word through a load port, and the block turns two of its fields into controls for the arithmetic datapath: a truncate-rounding select and a flush-denormals-to-zero select. The arithmetic itself lives elsewhere.

After every floating-point operation the datapath presents five raw exception indications with a valid strobe and an operation class. For arithmetic results the block re-derives the flag field from those indications, folds any raised exception into the sticky cause field, and asks the core for an FPU exception trap when a cause bit meets its enable bit. Compare operations own a separate result bit. An ordered compare only writes that bit. An unordered compare takes the exception path and leaves the bit alone. Sign-only operations leave all state as it was.

Word layout, bit 0 is the least significant bit: bits 1:0 rounding select, bits 6:2 flags, bits 11:7 enables, bits 17:12 causes (bit 17 is a sixth cause that software may write but the block never drives), bit 18 denormal flush. In every 5-bit field, and on the exception input, bit 0 is inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero and bit 4 invalid.

Top module: `fpsc_unit`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) sets csr_q to 0x00040001 and clears cmp_t and trap_req. This gives rnd_trunc = 1 and flush_dn = 1.
- R2: A load (ld_en high at an edge) makes csr_q equal ld_data AND 0x003FFFFF after that edge. Bits 31:22 always read as zero.
- R3: rnd_trunc is 1 exactly when csr_q[1:0] = 2'b01. The other three codes give 0, meaning round to nearest even.
- R4: flush_dn always equals csr_q[18].
- R5: An arithmetic operation (op_valid high, op_kind = 2'b00, ld_en low) replaces csr_q[6:2] with exc_raw at the next edge. This applies even when exc_raw is zero, in which case every flag clears.
- R6: In the same update, csr_q[16:12] becomes its old value ORed with exc_raw. Bit 17, the enables, the rounding select and bit 18 keep their values.
- R7: trap_req is high for the one cycle after an updating operation exactly when exc_raw is nonzero and (updated csr_q[16:12] AND csr_q[11:7]) is nonzero. Old cause bits count. trap_code is 0x120 while trap_req is high and 0 otherwise.
- R8: An ordered compare (op_kind = 2'b01, cmp_unord low) loads cmp_match into cmp_t. csr_q does not change and no trap is requested, whatever exc_raw carries.
- R9: An unordered compare (op_kind = 2'b01, cmp_unord high) leaves cmp_t unchanged and updates flags, causes and trap as in R5 to R7.
- R10: Sign-only operations (op_kind = 2'b10) and the unused class 2'b11 change neither csr_q nor cmp_t, and they request no trap.
- R11: When ld_en and op_valid are high at the same edge, the load wins. The operation is dropped and no trap is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Software load strobe |
| ld_data | input | 32 | Value to load into the status word |
| op_valid | input | 1 | One operation completes this cycle |
| op_kind | input | 2 | Operation class: 00 arithmetic, 01 compare, 10 sign-only, 11 none |
| exc_raw | input | 5 | Raised exceptions: bit 4 invalid, 3 divide-by-zero, 2 overflow, 1 underflow, 0 inexact |
| cmp_unord | input | 1 | Compare result is unordered |
| cmp_match | input | 1 | Compare relation holds (equal or greater-than) |
| csr_q | output | 32 | Current status and control word |
| rnd_trunc | output | 1 | Datapath rounds toward zero |
| flush_dn | output | 1 | Datapath flushes denormals to zero |
| cmp_t | output | 1 | Compare result bit |
| trap_req | output | 1 | One-cycle FPU exception trap request |
| trap_code | output | 12 | Exception code, 0x120 with a request |

## Verification
The hardest case to reach is a trap that a stale cause bit triggers. The current operation raises an exception whose own enable is off, yet a cause left sticky by an earlier operation meets its enable. Two other outcomes look almost the same: a nonzero stale cause with no new exception, which must not trap, and a trap that the current exception triggers. The stimulus loads a pre-set cause pattern before each operation. It then sweeps all 32 enable masks against all 32 exception patterns, and the preloaded cause differs from step to step, so all three outcomes appear many times.

// File: rtl/fpsc_pkg.sv
// Package: shared field positions, codes and operation classes for the
// floating-point status and trap controller. Assumes a word of at least
// 19 bits, since the denormal flush bit sits at position 18.
package fpsc_pkg;

    localparam int N_EXC     = 5;
    localparam int RM_LSB    = 0;
    localparam int RM_W      = 2;
    localparam int FLAG_LSB  = 2;
    localparam int EN_LSB    = FLAG_LSB + N_EXC;
    localparam int CAUSE_LSB = EN_LSB + N_EXC;
    localparam int CAUSE_W   = N_EXC + 1;
    localparam int DN_BIT    = CAUSE_LSB + CAUSE_W;

    localparam logic [RM_W-1:0] RM_TO_ZERO = 2'b01;

    typedef enum logic [1:0] {
        OP_ARITH = 2'b00,
        OP_CMP   = 2'b01,
        OP_SIGN  = 2'b10,
        OP_NONE  = 2'b11
    } op_kind_e;

endpackage

// File: rtl/fpsc_mode_decode.sv
// Module: turns the rounding select field and the denormal flush bit of the
// status word into datapath controls. Purely combinational. Assumes the
// round-to-zero code is the only one that selects truncation.
module fpsc_mode_decode
    import fpsc_pkg::*;
(
    input  logic [RM_W-1:0] rm_field,
    input  logic            dn_bit,
    output logic            rnd_trunc,
    output logic            flush_dn
);

    // Decode the rounding select and pass the flush bit through.
    always_comb begin
        rnd_trunc = (rm_field == RM_TO_ZERO);
        flush_dn  = dn_bit;
    end

endmodule

// File: rtl/fpsc_exc_merge.sv
// Module: computes the status word after an exception update, together with
// the trap decision. Flags are replaced by the raw exceptions, causes
// accumulate them, and a trap needs a raised exception plus a cause bit that
// meets its enable. Combinational. The caller decides when to commit.
module fpsc_exc_merge
    import fpsc_pkg::*;
#(
    parameter int REG_W = 32
) (
    input  logic [REG_W-1:0] csr_cur,
    input  logic [N_EXC-1:0] exc_raw,
    output logic [REG_W-1:0] csr_upd,
    output logic             trap_hit
);

    logic [N_EXC-1:0] cause_new;
    logic [N_EXC-1:0] hit_vec;
    logic             any_exc;

    // Per-exception cause accumulation and enable match.
    for (genvar gi = 0; gi < N_EXC; gi++) begin : g_bit
        always_comb begin
            cause_new[gi] = csr_cur[CAUSE_LSB + gi] | exc_raw[gi];
            hit_vec[gi]   = cause_new[gi] & csr_cur[EN_LSB + gi];
        end
    end

    // Assemble the updated word and the trap decision.
    always_comb begin
        any_exc                        = |exc_raw;
        csr_upd                        = csr_cur;
        csr_upd[FLAG_LSB +: N_EXC]     = exc_raw;
        csr_upd[CAUSE_LSB +: N_EXC]    = cause_new;
        trap_hit                       = any_exc & (|hit_vec);
    end

endmodule

// File: rtl/fpsc_cmp_flag.sv
// Module: holds the compare result bit. It is written only when the caller
// asserts set_en, and it clears on synchronous active-low reset.
module fpsc_cmp_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_en,
    input  logic set_val,
    output logic t_q
);

    // Result bit register.
    always_ff @(posedge clk) begin
        if (!rst_n)      t_q <= 1'b0;
        else if (set_en) t_q <= set_val;
    end

endmodule

// File: rtl/fpsc_unit.sv
// Module: top of the floating-point status and trap controller. It holds the
// status word, gives software loads priority over operation updates, and
// registers a one-cycle trap request on the same edge that commits the
// update. Assumes at most one operation is reported per cycle.
module fpsc_unit
    import fpsc_pkg::*;
#(
    parameter int               REG_W     = 32,
    parameter int               CODE_W    = 12,
    parameter logic [REG_W-1:0] RESET_VAL = 32'h0004_0001,
    parameter logic [REG_W-1:0] WR_MASK   = 32'h003F_FFFF,
    parameter logic [CODE_W-1:0] TRAP_CODE = 12'h120
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [REG_W-1:0]  ld_data,
    input  logic              op_valid,
    input  logic [1:0]        op_kind,
    input  logic [N_EXC-1:0]  exc_raw,
    input  logic              cmp_unord,
    input  logic              cmp_match,
    output logic [REG_W-1:0]  csr_q,
    output logic              rnd_trunc,
    output logic              flush_dn,
    output logic              cmp_t,
    output logic              trap_req,
    output logic [CODE_W-1:0] trap_code
);

    op_kind_e         kind;
    logic             is_arith;
    logic             is_cmp;
    logic             do_update;
    logic             cmp_write;
    logic [REG_W-1:0] csr_upd;
    logic             trap_hit;
    logic             trap_q;

    // Classify the reported operation. A load suppresses it.
    always_comb begin
        kind      = op_kind_e'(op_kind);
        is_arith  = op_valid && (kind == OP_ARITH);
        is_cmp    = op_valid && (kind == OP_CMP);
        do_update = !ld_en && (is_arith || (is_cmp && cmp_unord));
        cmp_write = !ld_en && is_cmp && !cmp_unord;
    end

    fpsc_exc_merge #(.REG_W(REG_W)) i_merge (
        .csr_cur  (csr_q),
        .exc_raw  (exc_raw),
        .csr_upd  (csr_upd),
        .trap_hit (trap_hit)
    );

    // Status word register: reset, then load, then exception update.
    always_ff @(posedge clk) begin
        if (!rst_n)         csr_q <= RESET_VAL & WR_MASK;
        else if (ld_en)     csr_q <= ld_data & WR_MASK;
        else if (do_update) csr_q <= csr_upd & WR_MASK;
    end

    // Trap pulse register, one cycle per trapping update.
    always_ff @(posedge clk) begin
        if (!rst_n) trap_q <= 1'b0;
        else        trap_q <= do_update && trap_hit;
    end

    fpsc_cmp_flag i_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (cmp_write),
        .set_val (cmp_match),
        .t_q     (cmp_t)
    );

    fpsc_mode_decode i_mode (
        .rm_field  (csr_q[RM_LSB +: RM_W]),
        .dn_bit    (csr_q[DN_BIT]),
        .rnd_trunc (rnd_trunc),
        .flush_dn  (flush_dn)
    );

    // Drive the trap outputs. The code is zero when no request is active.
    always_comb begin
        trap_req  = trap_q;
        trap_code = trap_q ? TRAP_CODE : '0;
    end

endmodule

// File: rtl/fpsc_unit_chk.sv
// Module: assertion checker for fpsc_unit. It observes only the top ports and
// is attached with the bind statement at the end of this file.
module fpsc_unit_chk
    import fpsc_pkg::*;
#(
    parameter int               REG_W   = 32,
    parameter int               CODE_W  = 12,
    parameter logic [REG_W-1:0] WR_MASK = 32'h003F_FFFF,
    parameter logic [CODE_W-1:0] TRAP_CODE = 12'h120
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ld_en,
    input logic [REG_W-1:0]  ld_data,
    input logic              op_valid,
    input logic [1:0]        op_kind,
    input logic [N_EXC-1:0]  exc_raw,
    input logic              cmp_unord,
    input logic              cmp_match,
    input logic [REG_W-1:0]  csr_q,
    input logic              rnd_trunc,
    input logic              flush_dn,
    input logic              cmp_t,
    input logic              trap_req,
    input logic [CODE_W-1:0] trap_code
);

    // R2
    load_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> csr_q == ($past(ld_data) & WR_MASK));

    // R3
    round_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_trunc == (csr_q[RM_LSB +: RM_W] == RM_TO_ZERO));

    // R4
    flush_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_dn == csr_q[DN_BIT]);

    // R5
    flag_replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'b00 && !ld_en)
        |=> csr_q[FLAG_LSB +: N_EXC] == $past(exc_raw));

    // R7
    trap_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |-> trap_code == TRAP_CODE);

    // R7
    trap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_req |-> trap_code == '0);

    // R7
    trap_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_valid || ld_en || exc_raw == '0) |=> !trap_req);

    // R8
    cmp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'b01 && !cmp_unord && !ld_en)
        |=> ($stable(csr_q) && !trap_req && cmp_t == $past(cmp_match)));

    // R9
    cmp_unord_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind == 2'b01 && cmp_unord) |=> $stable(cmp_t));

    // R10
    sign_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_kind[1] && !ld_en)
        |=> ($stable(csr_q) && $stable(cmp_t) && !trap_req));

endmodule

bind fpsc_unit fpsc_unit_chk #(
    .REG_W     (REG_W),
    .CODE_W    (CODE_W),
    .WR_MASK   (WR_MASK),
    .TRAP_CODE (TRAP_CODE)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_en     (ld_en),
    .ld_data   (ld_data),
    .op_valid  (op_valid),
    .op_kind   (op_kind),
    .exc_raw   (exc_raw),
    .cmp_unord (cmp_unord),
    .cmp_match (cmp_match),
    .csr_q     (csr_q),
    .rnd_trunc (rnd_trunc),
    .flush_dn  (flush_dn),
    .cmp_t     (cmp_t),
    .trap_req  (trap_req),
    .trap_code (trap_code)
);

// File: tb/test_fpsc_unit.sv
// Bench for fpsc_unit. It sweeps enable masks against exception patterns
// with preloaded causes and computes every expected value arithmetically.
module test_fpsc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [31:0] ld_data = '0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_kind = 2'b00;
    logic [4:0]  exc_raw = '0;
    logic        cmp_unord = 1'b0;
    logic        cmp_match = 1'b0;
    logic [31:0] csr_q;
    logic        rnd_trunc;
    logic        flush_dn;
    logic        cmp_t;
    logic        trap_req;
    logic [11:0] trap_code;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    fpsc_unit i_fpsc_unit (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_data(ld_data),
        .op_valid(op_valid), .op_kind(op_kind), .exc_raw(exc_raw),
        .cmp_unord(cmp_unord), .cmp_match(cmp_match), .csr_q(csr_q),
        .rnd_trunc(rnd_trunc), .flush_dn(flush_dn), .cmp_t(cmp_t),
        .trap_req(trap_req), .trap_code(trap_code)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // Load a word; returns after the edge that commits it.
    task automatic do_load(input logic [31:0] val);
        @(negedge clk);
        ld_en = 1'b1; ld_data = val;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    // Report one operation; returns after the edge that commits it.
    task automatic do_op(input logic [1:0] kind, input logic [4:0] ex,
                         input logic unord, input logic match);
        @(negedge clk);
        op_valid = 1'b1; op_kind = kind; exc_raw = ex;
        cmp_unord = unord; cmp_match = match;
        @(negedge clk);
        op_valid = 1'b0; exc_raw = '0; cmp_unord = 1'b0; cmp_match = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        logic [31:0] ld;
        logic [31:0] exp_csr;
        logic [4:0]  cause5;
        logic [5:0]  pc;
        logic        exp_trap;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 csr", csr_q, 32'h0004_0001);
        check("R1 trunc/flush", {30'd0, rnd_trunc, flush_dn}, 32'h3);
        check("R1 t/trap", {30'd0, cmp_t, trap_req}, 32'h0);

        // R2: writable mask
        do_load(32'hFFFF_FFFF);
        check("R2 all ones", csr_q, 32'h003F_FFFF);
        do_load(32'hA5C3_5A3C);
        check("R2 pattern", csr_q, 32'hA5C3_5A3C & 32'h003F_FFFF);

        // R3, R4: every rounding code with both flush settings
        for (int rm = 0; rm < 4; rm++) begin
            for (int dn = 0; dn < 2; dn++) begin
                do_load(32'(rm) | (32'(dn) << 18));
                check("R3 trunc", {31'd0, rnd_trunc}, {31'd0, rm == 1});
                check("R4 flush", {31'd0, flush_dn}, 32'(dn));
            end
        end

        // R5, R6, R7: enable x exception sweep with preloaded causes
        for (int en = 0; en < 32; en++) begin
            for (int ex = 0; ex < 32; ex++) begin
                pc = 6'((en * 7 + ex * 3 + 5) % 64);
                ld = (32'(pc) << 12) | (32'(en) << 7) | (32'((en ^ 21) & 31) << 2)
                   | 32'(ex % 4) | (32'(en % 2) << 18);
                do_load(ld);
                do_op(2'b00, 5'(ex), 1'b0, 1'b0);
                cause5   = (ex != 0) ? (pc[4:0] | 5'(ex)) : pc[4:0];
                exp_csr  = (ld & ~32'h0001_F07C) | (32'(ex) << 2) | (32'(cause5) << 12);
                exp_trap = (ex != 0) && ((cause5 & 5'(en)) != 0);
                check("R5/R6 csr after update", csr_q, exp_csr);
                check("R7 trap", {31'd0, trap_req}, {31'd0, exp_trap});
                check("R7 code", {20'd0, trap_code}, exp_trap ? 32'h120 : 32'h0);
            end
        end

        // R7: pulse lasts one cycle
        do_load(32'h0000_0F80);
        do_op(2'b00, 5'h01, 1'b0, 1'b0);
        check("R7 pulse high", {31'd0, trap_req}, 32'h1);
        @(negedge clk);
        check("R7 pulse one cycle", {31'd0, trap_req}, 32'h0);

        // R8: ordered compares write the bit only
        do_load(32'h0000_0FFC);
        do_op(2'b01, 5'h1F, 1'b0, 1'b1);
        check("R8 t set", {31'd0, cmp_t}, 32'h1);
        check("R8 csr kept", csr_q, 32'h0000_0FFC);
        check("R8 no trap", {31'd0, trap_req}, 32'h0);
        do_op(2'b01, 5'h1F, 1'b0, 1'b0);
        check("R8 t clear", {31'd0, cmp_t}, 32'h0);

        // R9: unordered compare keeps the bit and updates exceptions
        do_op(2'b01, 5'h00, 1'b0, 1'b1);
        do_load(32'h0000_0800);
        do_op(2'b01, 5'h10, 1'b1, 1'b0);
        check("R9 t kept", {31'd0, cmp_t}, 32'h1);
        check("R9 csr", csr_q, 32'h0001_0840);
        check("R9 trap", {31'd0, trap_req}, 32'h1);

        // R10: sign-only and unused class have no effect
        do_load(32'h0001_FFFC);
        do_op(2'b10, 5'h1F, 1'b0, 1'b0);
        check("R10 sign csr", csr_q, 32'h0001_FFFC);
        check("R10 sign trap/t", {30'd0, trap_req, cmp_t}, 32'h1);
        do_op(2'b11, 5'h1F, 1'b1, 1'b0);
        check("R10 none csr", csr_q, 32'h0001_FFFC);
        check("R10 none trap/t", {30'd0, trap_req, cmp_t}, 32'h1);

        // R11: load and operation at the same edge
        @(negedge clk);
        ld_en = 1'b1; ld_data = 32'h0000_0F80;
        op_valid = 1'b1; op_kind = 2'b00; exc_raw = 5'h1F;
        @(negedge clk);
        ld_en = 1'b0; op_valid = 1'b0; exc_raw = '0;
        check("R11 load wins", csr_q, 32'h0000_0F80);
        check("R11 no trap", {31'd0, trap_req}, 32'h0);

        done = 1'b1;
        report();
        $finish;
    end

endmodule